// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands over several clock cycles. Each cycle it retires two bits of the multiplier. Each pair of multiplier bits, read together with the bit just below it (an implicit zero sits under bit 0), is recoded into a signed digit in the range -2 to +2. The digit picks 0, the multiplicand or twice the multiplicand. That multiple is then added to or subtracted from a running partial product. The partial product shifts right two places per cycle with sign fill. The hard multiple of three times the multiplicand is therefore never formed, and a WIDTH-bit multiply takes WIDTH/2 iteration cycles.

A caller presents both operands with a one-cycle `start` while the block is idle. A later `done` pulse marks the moment the full 2*WIDTH-bit product is on `product`. The product then stays there until the next accepted start. While a multiply is running, further start requests are ignored.

Top module: `boothMul`

## Requirements
- R1: After reset `done` is low and `product` is zero.
- R2: When `done` is high, `product` equals the signed product of the two operands captured at the accepted start, as a 2*WIDTH-bit two's-complement value.
- R3: `done` is high for exactly one cycle, on the clock edge WIDTH/2 cycles after the edge that accepted `start`.
- R4: A `start` seen while a multiply is running is ignored: the running multiply finishes with its own operands and no extra `done` occurs.
- R5: While idle with `start` low, `product` holds its value, whatever the operand inputs do.
- R6: Each multiplier triple {x(i+1), x(i), x(i-1)} recodes as 000 to 0, 001 to +1, 010 to +1, 011 to +2, 100 to -2, 101 to -1, 110 to -1 and 111 to 0. Multipliers with repeating bit patterns therefore give exact products.
- R7: Extreme operands give exact results without overflow, including the most negative value times itself (+2^(2*WIDTH-2)).
- R8: A `start` in the same cycle that `done` is high is accepted, so multiplies can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; sampled only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on accepted start |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The hardest case to reach from the ports is the largest partial sum. It arises when a -2 digit meets the most negative multiplicand, and the k+2-bit adder only matters there. The stimulus drives the most negative value against itself and against the most positive value. It also drives multipliers such as 0x55, 0xAA, 0x33 and 0xCC, which push every recoding triple through in turn. A second stimulus raises `start` with different operands while a multiply is in flight. The next one raises `start` in the very cycle of a `done`. Together these show that requests are accepted only when idle.

// File: rtl/boothMulPkg.sv
package boothMulPkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear partial product
    logic step;  // one radix-4 iteration
  } mulStrobes_t;
endpackage

// File: rtl/boothRecoder.sv
module boothRecoder (
  input  logic [2:0] triple,   // {x(i+1), x(i), x(i-1)}
  output logic       nonZero,
  output logic       twoX,
  output logic       negate
);
  always_comb begin
    nonZero = 1'b0;
    twoX    = 1'b0;
    negate  = 1'b0;
    unique case (triple)
      3'b001, 3'b010: nonZero = 1'b1;
      3'b011: begin nonZero = 1'b1; twoX = 1'b1; end
      3'b100: begin nonZero = 1'b1; twoX = 1'b1; negate = 1'b1; end
      3'b101, 3'b110: begin nonZero = 1'b1; negate = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/boothCtrl.sv
module boothCtrl
  import boothMulPkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        done
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  typedef enum logic { IDLE, RUN } state_t;
  state_t        state;
  logic [CW-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        IDLE: if (start) begin
          state   <= RUN;
          stepCnt <= '0;
        end
        RUN: if (stepCnt == CW'(STEPS - 1)) begin
          state <= IDLE;
          done  <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.load = (state == IDLE) && start;
    strobes.step = (state == RUN);
  end
endmodule

// File: rtl/boothDatapath.sv
module boothDatapath
  import boothMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobes_t        strobes,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int ADDW = WIDTH + 2;

  logic [WIDTH-1:0] aReg;
  logic [ADDW-1:0]  hiReg;
  logic [WIDTH-1:0] loReg;
  logic             prevBit;

  logic nonZero, twoX, negate;
  boothRecoder u_recoder (
    .triple  ({loReg[1:0], prevBit}),
    .nonZero (nonZero),
    .twoX    (twoX),
    .negate  (negate)
  );

  logic [ADDW-1:0] oneA, twoA, picked, operand, sum;
  always_comb begin
    oneA    = {{2{aReg[WIDTH-1]}}, aReg};
    twoA    = {aReg[WIDTH-1], aReg, 1'b0};
    picked  = nonZero ? (twoX ? twoA : oneA) : '0;
    operand = negate ? ~picked : picked;
    sum     = hiReg + operand + ADDW'(negate);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      hiReg   <= '0;
      loReg   <= '0;
      prevBit <= 1'b0;
    end else if (strobes.load) begin
      aReg    <= multiplicand;
      hiReg   <= '0;
      loReg   <= multiplier;
      prevBit <= 1'b0;
    end else if (strobes.step) begin
      hiReg   <= {{2{sum[ADDW-1]}}, sum[ADDW-1:2]};
      loReg   <= {sum[1:0], loReg[WIDTH-1:2]};
      prevBit <= loReg[1];
    end
  end

  assign product = {hiReg[WIDTH-1:0], loReg};
endmodule

// File: rtl/boothMul.sv
module boothMul
  import boothMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int STEPS = WIDTH / 2;

  mulStrobes_t strobes;

  boothCtrl #(.STEPS(STEPS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  boothDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );
endmodule

// File: rtl/boothMulChecker.sv
module boothMulChecker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic             ckBusy;
  logic [CW-1:0]    ckCnt;
  logic [WIDTH-1:0] ckA, ckB;
  logic             lastStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckBusy <= 1'b0;
      ckCnt  <= '0;
      ckA    <= '0;
      ckB    <= '0;
    end else if (!ckBusy) begin
      if (start) begin
        ckBusy <= 1'b1;
        ckCnt  <= '0;
        ckA    <= multiplicand;
        ckB    <= multiplier;
      end
    end else if (ckCnt == CW'(STEPS - 1)) begin
      ckBusy <= 1'b0;
    end else begin
      ckCnt <= ckCnt + 1'b1;
    end
  end

  assign lastStep = ckBusy && (ckCnt == CW'(STEPS - 1));

  logic signed [2*WIDTH-1:0] extA, extB, ckExp;
  assign extA  = {{WIDTH{ckA[WIDTH-1]}}, ckA};
  assign extB  = {{WIDTH{ckB[WIDTH-1]}}, ckB};
  assign ckExp = extA * extB;

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    lastStep |=> done);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    !lastStep |=> !done);
  assert_product_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == ckExp));
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ckBusy && !start) |=> $stable(product));
endmodule

bind boothMul boothMulChecker #(.WIDTH(WIDTH)) u_boothMulChecker (.*);

// File: tb/test_boothMul.sv
module test_boothMul;
  localparam int W     = 8;
  localparam int STEPS = W / 2;

  logic           clk = 1'b0;
  logic           rstN;
  logic           start;
  logic [W-1:0]   multiplicand, multiplier;
  logic           done;
  logic [2*W-1:0] product;

  boothMul #(.WIDTH(W)) i_boothMul (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .done(done), .product(product)
  );

  always #2 clk = ~clk;   // 250 MHz

  typedef struct {
    logic [2*W-1:0] prod;
    int             cyc;
    string          tag;
  } expItem_t;

  expItem_t       sbQ[$];
  int             cyc = 0;
  int             nChecks = 0;
  int             nFail = 0;
  logic [2*W-1:0] lastProd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag,
                       input longint actual, input longint expected);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // driver: call between a falling and the next rising edge while idle
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] x, input string tag);
    expItem_t it;
    longint   pr;
    pr      = longint'($signed(a)) * longint'($signed(x));
    it.prod = pr[2*W-1:0];
    it.cyc  = cyc + 1 + STEPS;
    it.tag  = tag;
    sbQ.push_back(it);
    lastProd     = it.prod;
    start        = 1'b1;
    multiplicand = a;
    multiplier   = x;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    #1;
    while (sbQ.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] x, input string tag);
    issue(a, x, tag);
    waitIdle();
  endtask

  // monitor: compares each completed product against the scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R4 spurious done", 1, 0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        check(product == it.prod, it.tag, product, it.prod);
        check(cyc == it.cyc, "R3 done latency", cyc, it.cyc);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run hung, cycle %0d", cyc);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    rstN = 1'b0;
    start = 1'b0;
    multiplicand = '0;
    multiplier = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(product == '0, "R1 product after reset", product, 0);
    #1;

    // R2: basic values, including 6 x -6
    runOp(8'd6, 8'hFA, "R2 6*-6");
    runOp(8'd0, 8'h5B, "R2 zero multiplicand");
    runOp(8'd1, 8'hFF, "R2 1*-1");
    runOp(8'd13, 8'd11, "R2 13*11");

    // R6: repeating patterns visit every recoding triple
    runOp(8'd6,  8'h55, "R6 x=0x55");
    runOp(8'd6,  8'hAA, "R6 x=0xAA");
    runOp(8'hFA, 8'h33, "R6 x=0x33");
    runOp(8'hFA, 8'hCC, "R6 x=0xCC");
    runOp(8'h5D, 8'h0F, "R6 x=0x0F");
    runOp(8'h5D, 8'hF0, "R6 x=0xF0");
    runOp(8'h81, 8'hFF, "R6 x=0xFF");
    runOp(8'h81, 8'h00, "R6 x=0x00");
    runOp(8'h6B, 8'h6A, "R6 x=0x6A");

    // R7: extremes
    runOp(8'h80, 8'h80, "R7 min*min");
    runOp(8'h80, 8'h7F, "R7 min*max");
    runOp(8'h7F, 8'h80, "R7 max*min");
    runOp(8'h7F, 8'h7F, "R7 max*max");
    runOp(8'h80, 8'hAA, "R7 min*0xAA");

    // R5: product holds while idle although operands change
    runOp(8'h3C, 8'hC5, "R5 setup");
    multiplicand = 8'h11;
    multiplier   = 8'h22;
    repeat (6) @(negedge clk);
    check(product == lastProd, "R5 hold while idle", product, lastProd);
    check(done == 1'b0, "R5 no done while idle", done, 0);
    #1;

    // R4: start while running is ignored
    issue(8'h25, 8'hE3, "R4 running op");
    start = 1'b1;
    multiplicand = 8'h7F;
    multiplier   = 8'h7F;
    repeat (2) @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (STEPS + 2) @(negedge clk);
    check(product == lastProd, "R4 product unchanged after ignored start", product, lastProd);
    #1;

    // R8: back-to-back start in the done cycle
    issue(8'h9C, 8'h47, "R8 first");
    do @(negedge clk); while (!done);
    #1;
    issue(8'hD2, 8'h8B, "R8 second");
    waitIdle();

    // R2: pseudo-random operands
    lcg = 32'h1234_5678;
    for (int i = 0; i < 24; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      runOp(lcg[23:16], lcg[31:24], "R2 random");
    end

    repeat (5) @(negedge clk);
    check(sbQ.size() == 0, "R3 all products delivered", sbQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule